// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns one operand specifier into a memory address. Each request gives an addressing-mode code, an operand size, the number and current value of the address register that forms the base, the program counter, an index value and an extension value that has already been fetched. One clock later the unit presents the operand address, an odd-address fault flag and, for the two auto-modify modes, the new value to write back into the base register.

Eight modes are covered: plain register indirect, post-increment, pre-decrement, base plus a signed 16-bit displacement, base plus a sized index plus a signed 8-bit displacement, absolute, and the two program-counter-based forms (displacement and index). The unit does not fetch memory or extension words, and it does not own the register file. The caller reads the registers, supplies their values and applies the writeback.

Top module: `ea_gen`

## Requirements
- R1: While reset (rst_n low) is asserted and on the first cycle after it, res_vld_o and wb_en_o are 0.
- R2: A request is accepted on a rising edge with req_i high, and its results appear with res_vld_o high in the following cycle. With req_i low, res_vld_o is 0 in the following cycle.
- R3: Mode 0 (register indirect) gives address = base_i. Mode 5 (absolute) gives address = ext_i unchanged. Neither mode asserts wb_en_o.
- R4: Mode 1 (post-increment) gives address = base_i, wb_en_o = 1 and wb_val_o = base_i + step. The step is 1 for size code 0 (byte), 2 for size code 1 (word) and 4 for size code 2 or 3 (long). The sum wraps at 32 bits.
- R5: Mode 2 (pre-decrement) gives address = wb_val_o = base_i − step, modulo 2^32, with wb_en_o = 1.
- R6: In modes 1 and 2 with byte size and reg_num_i = 7, the step is 2.
- R7: Mode 3 gives address = base_i + sign-extended ext_i[15:0], modulo 2^32.
- R8: Mode 4 gives address = base_i + index + sign-extended ext_i[7:0]. The index is idx_i when idx_long_i = 1, and sign-extended idx_i[15:0] otherwise.
- R9: Modes 6 and 7 follow the rules of modes 3 and 4, with pc_i used as the base in place of base_i.
- R10: addr_err_o is 1 exactly when the size is not byte and bit 0 of the produced address is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code 0..7 |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| reg_num_i | input | 3 | Base address register number |
| base_i | input | 32 | Base address register value |
| pc_i | input | 32 | Program counter value |
| idx_i | input | 32 | Index register value (data or address) |
| idx_long_i | input | 1 | Index used at long size when 1, word when 0 |
| ext_i | input | 32 | Displacement or absolute address |
| res_vld_o | output | 1 | Results valid |
| addr_o | output | 32 | Operand address |
| addr_err_o | output | 1 | Odd address for a word or long access |
| wb_en_o | output | 1 | Base register writeback enable |
| wb_val_o | output | 32 | New base register value |

## Verification
A writeback and an address fault can occur in the same cycle. This happens when a word or long post-increment or pre-decrement runs on an odd base value. The sweep provokes it by putting odd bases through every mode and size. In those cycles it requires both the fault flag and the correct writeback value: the fault must not suppress the register update, and the update must not hide the fault. The byte-size stack register case is judged in the same sweep, because there the step of 2 must also leave the fault flag clear.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    reg_num_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] idx_i,
  input  logic          idx_long_i,
  input  logic [AW-1:0] ext_i,
  output logic          res_vld_o,
  output logic [AW-1:0] addr_o,
  output logic          addr_err_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  localparam logic [2:0] M_IND = 3'd0, M_INC = 3'd1, M_DEC = 3'd2, M_D16 = 3'd3,
                         M_IX = 3'd4, M_ABS = 3'd5, M_PCD = 3'd6, M_PCX = 3'd7;

  logic [AW-1:0] step, d16, d8, ix, root, bumped, dropped, ea;
  logic          is_byte;

  assign is_byte = (size_i == 2'd0);
  assign step    = is_byte ? ((reg_num_i == 3'd7) ? AW'(2) : AW'(1))
                 : (size_i == 2'd1) ? AW'(2) : AW'(4);
  assign d16     = {{(AW-16){ext_i[15]}}, ext_i[15:0]};
  assign d8      = {{(AW-8){ext_i[7]}}, ext_i[7:0]};
  assign ix      = idx_long_i ? idx_i : {{(AW-16){idx_i[15]}}, idx_i[15:0]};
  assign root    = (mode_i == M_PCD || mode_i == M_PCX) ? pc_i : base_i;
  assign bumped  = base_i + step;
  assign dropped = base_i - step;

  always_comb begin
    unique case (mode_i)
      M_DEC:        ea = dropped;
      M_D16, M_PCD: ea = root + d16;
      M_IX, M_PCX:  ea = root + ix + d8;
      M_ABS:        ea = ext_i;
      default:      ea = base_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld_o  <= 1'b0;
      wb_en_o    <= 1'b0;
      addr_o     <= '0;
      addr_err_o <= 1'b0;
      wb_val_o   <= '0;
    end else begin
      res_vld_o <= req_i;
      wb_en_o   <= req_i && (mode_i == M_INC || mode_i == M_DEC);
      if (req_i) begin
        addr_o     <= ea;
        addr_err_o <= !is_byte && ea[0];
        wb_val_o   <= (mode_i == M_INC) ? bumped : dropped;
      end
    end
  end

  // R1
  wb_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> res_vld_o);

  // R2
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $past(req_i));

  // R3
  abs_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $past(mode_i) == M_ABS) |-> (addr_o == $past(ext_i) && !wb_en_o));

  // R5
  predec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $past(mode_i) == M_DEC) |-> (wb_en_o && wb_val_o == addr_o));

  // R4
  postinc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $past(mode_i) == M_INC) |-> (addr_o == $past(base_i)));

  // R10
  byte_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && $past(size_i) == 2'd0) |-> !addr_err_o);
endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  logic        clk = 0, rst_n = 0, req_i = 0, idx_long_i = 0;
  logic [2:0]  mode_i = 0, reg_num_i = 0;
  logic [1:0]  size_i = 0;
  logic [31:0] base_i = 0, pc_i = 0, idx_i = 0, ext_i = 0;
  logic        res_vld_o, addr_err_o, wb_en_o;
  logic [31:0] addr_o, wb_val_o;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ea_gen dut_i (.clk, .rst_n, .req_i, .mode_i, .size_i, .reg_num_i, .base_i, .pc_i,
                .idx_i, .idx_long_i, .ext_i, .res_vld_o, .addr_o, .addr_err_o,
                .wb_en_o, .wb_val_o);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h (mode=%0d size=%0d reg=%0d)", tag, act, exp, mode_i, size_i, reg_num_i);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, ix, ea, ewb, root;
    string tag;
    repeat (3) @(negedge clk);
    chk(res_vld_o == 0, "R1", res_vld_o, 0);
    chk(wb_en_o == 0, "R1", wb_en_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(res_vld_o == 0 && wb_en_o == 0, "R1", {res_vld_o, wb_en_o}, 0);
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int r = 0; r < 8; r++)
          for (int v = 0; v < 4; v++) begin
            mode_i = 3'(m); size_i = 2'(s); reg_num_i = 3'(r);
            base_i = (v == 0) ? 32'h0 : (v == 1) ? 32'hFFFF_FFFF : (v == 2) ? 32'h1000_0003 : 32'h8000_0010 + 32'(r);
            pc_i   = 32'h0000_4000 + 32'(v);
            idx_i  = (v[0]) ? 32'h0001_FFF0 : 32'h0000_8002 + 32'(s);
            idx_long_i = v[1];
            ext_i  = (v == 1) ? 32'h1234_FF81 : (v == 2) ? 32'h0000_8000 : 32'hABCD_007E + 32'(r);
            req_i  = 1;
            st = (s == 0) ? ((r == 7) ? 2 : 1) : (s == 1) ? 2 : 4;
            ix = idx_long_i ? idx_i : {{16{idx_i[15]}}, idx_i[15:0]};
            root = (m >= 6) ? pc_i : base_i;
            ewb = 0;
            case (m)
              0: begin ea = base_i; tag = "R3"; end
              1: begin ea = base_i; ewb = base_i + st; tag = (s == 0 && r == 7) ? "R6" : "R4"; end
              2: begin ea = base_i - st; ewb = ea; tag = (s == 0 && r == 7) ? "R6" : "R5"; end
              3: begin ea = root + {{16{ext_i[15]}}, ext_i[15:0]}; tag = "R7"; end
              4: begin ea = root + ix + {{24{ext_i[7]}}, ext_i[7:0]}; tag = "R8"; end
              5: begin ea = ext_i; tag = "R3"; end
              6: begin ea = root + {{16{ext_i[15]}}, ext_i[15:0]}; tag = "R9"; end
              default: begin ea = root + ix + {{24{ext_i[7]}}, ext_i[7:0]}; tag = "R9"; end
            endcase
            @(negedge clk);
            req_i = 0;
            chk(res_vld_o == 1, "R2", res_vld_o, 1);
            chk(addr_o == ea, tag, addr_o, ea);
            chk(wb_en_o == (m == 1 || m == 2), tag, wb_en_o, (m == 1 || m == 2));
            if (m == 1 || m == 2) chk(wb_val_o == ewb, tag, wb_val_o, ewb);
            chk(addr_err_o == (s != 0 && ea[0]), "R10", addr_err_o, (s != 0 && ea[0]));
            if (v == 3) begin
              @(negedge clk);
              chk(res_vld_o == 0 && wb_en_o == 0, "R2", {res_vld_o, wb_en_o}, 0);
            end
          end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule